// File: doc/BRIEF.md
# Pipeline Bypass and Load-Use Interlock Control

This block is the hazard control for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory, writeback. It looks at the source register fields of the instruction in decode and of the instruction in execute. It compares them with the destinations that the two later pipeline registers, execute/memory and memory/writeback, are about to write. From that comparison it drives the bypass multiplexer selects for both ALU operands and for store data, and a stall request.

Registers are always read in decode and written in writeback. For that reason only read-after-write dependences can occur, and those are the only ones handled. Most dependences are met by forwarding. A load followed at once by an instruction that needs the loaded value in the ALU cannot be met that way, so the block raises `stall` for one cycle. While `stall` is high, the surrounding pipeline holds the PC and the fetch/decode register and loads a no-op with write enable cleared into the decode/execute register. A store whose data register is written by the load just ahead of it needs no stall: the loaded word is forwarded into the store's data path during its memory stage.

The block is purely combinational. The register file, the ALU, the memories and the pipeline registers are outside it.

Top module: `hazard_ctrl`

## Requirements
- R1: Each bypass select is 2 bits wide, with these codes: 00 = register file value, 01 = result held in the execute/memory register, 10 = write value held in the memory/writeback register. `fwd_a` covers the source field at instruction bits 25:21 of the instruction in execute, and `fwd_b` covers the field at bits 20:16. A select is 01 when the execute/memory stage writes that source register.
- R2: A select is 10 when the memory/writeback stage writes the source register and the execute/memory stage does not.
- R3: When both later stages write the same source register, the execute/memory stage (the younger result) wins and the select is 01.
- R4: Register 0 never causes a forward, a store-data forward or a stall, even if a stage claims to write it.
- R5: A select stays 00 when the operand is not read by the consuming instruction, or when the matching stage's write enable is clear. With every stage idle, all selects are 00 and `stall` is 0.
- R6: `stall` is 1 exactly when the instruction in execute is a load with its write enable set and a nonzero destination, and that destination equals a source of the decode instruction that the ALU reads. After the single bubble the consumer is not stalled again, and it then receives the loaded value through select 10.
- R7: `fwd_sd` selects the store data of a store in execute (source bits 20:16) with the same codes and priority as R1 to R3. It never takes 01 from a load in execute/memory, because that register holds the load's address and not its data.
- R8: `fwd_mem_sd` is 10 when the store in the memory stage takes its data from the register that a load in memory/writeback writes (write enable set, nonzero register). Otherwise it is 00.
- R9: A decode instruction that depends on a load in execute only through its store data (it does not read that register as an ALU operand) does not stall.
- R10: The destination of the instruction in execute is bits 15:11 when `ex_rr_fmt` is 1 (register-register format) and bits 20:16 when it is 0 (register-immediate format).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in decode |
| id_use_rs1 | input | 1 | Decode instruction reads field 25:21 as an ALU operand |
| id_use_rs2 | input | 1 | Decode instruction reads field 20:16 as an ALU operand |
| ex_instr | input | 32 | Instruction word in execute |
| ex_rr_fmt | input | 1 | Execute instruction is register-register format |
| ex_use_rs1 | input | 1 | Execute instruction reads field 25:21 in the ALU |
| ex_use_rs2 | input | 1 | Execute instruction reads field 20:16 in the ALU |
| ex_store | input | 1 | Execute instruction is a store; field 20:16 is its data |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination held in the execute/memory register |
| mem_wen | input | 1 | Execute/memory instruction writes a register |
| mem_load | input | 1 | Execute/memory instruction is a load |
| mem_store | input | 1 | Execute/memory instruction is a store |
| mem_sd_reg | input | 5 | Data register of the store in the memory stage |
| wb_rd | input | 5 | Destination held in the memory/writeback register |
| wb_wen | input | 1 | Memory/writeback instruction writes a register |
| wb_load | input | 1 | Memory/writeback instruction carries load data |
| fwd_a | output | 2 | Bypass select for ALU operand A |
| fwd_b | output | 2 | Bypass select for ALU operand B |
| fwd_sd | output | 2 | Bypass select for store data in execute |
| fwd_mem_sd | output | 2 | Bypass select for store data in the memory stage |
| stall | output | 1 | Hold PC and fetch/decode, insert bubble into decode/execute |

## Verification
The assertions assume that the flags describe instructions that can really occur. In particular, the use flags are meaningful only together with the register fields they qualify, and a load in execute/memory whose destination an ALU operand in execute reads does not arise, because R6 would have stalled it. The random stimulus draws register numbers from a small range so that matches and register 0 come up often. It sets flags independently, including the combinations that the interlock guarantees never occur. The expected values follow the requirements for every combination, so the bench needs no stimulus filter. Directed sequences add the load-use bubble, the load-then-store pairing and both destination formats.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int REG_AW = 5;
  localparam int INSTR_W = 32;

  typedef enum logic [1:0] {
    BYP_RF   = 2'b00,
    BYP_NEAR = 2'b01,
    BYP_FAR  = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/reg_field_split.sv
module reg_field_split #(
  parameter int IW = 32,
  parameter int AW = 5,
  parameter int SRCA_LSB = 21,
  parameter int SRCB_LSB = 16,
  parameter int DST_LSB = 11
) (
  input  logic [IW-1:0] instr,
  input  logic          rr_fmt,
  output logic [AW-1:0] src_a,
  output logic [AW-1:0] src_b,
  output logic [AW-1:0] dest
);
  localparam int TOP_USED = SRCA_LSB + AW;

  logic unused_bits;
  assign unused_bits = ^{instr[IW-1:TOP_USED], instr[DST_LSB-1:0]};

  assign src_a = instr[SRCA_LSB +: AW];
  assign src_b = instr[SRCB_LSB +: AW];
  assign dest  = rr_fmt ? instr[DST_LSB +: AW] : instr[SRCB_LSB +: AW];
endmodule

// File: rtl/byp_pick.sv
module byp_pick
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic          near_ok,
  input  logic [AW-1:0] near_rd,
  input  logic          near_wen,
  input  logic [AW-1:0] far_rd,
  input  logic          far_wen,
  output logic [1:0]    sel
);
  logic live, near_hit, far_hit;

  assign live     = used && (src != '0);
  assign near_hit = live && near_ok && near_wen && (near_rd == src);
  assign far_hit  = live && far_wen && (far_rd == src);

  always_comb begin
    if (near_hit)     sel = BYP_NEAR;
    else if (far_hit) sel = BYP_FAR;
    else              sel = BYP_RF;
  end
endmodule

// File: rtl/load_use_check.sv
module load_use_check #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_a,
  input  logic [AW-1:0] dec_b,
  input  logic          dec_use_a,
  input  logic          dec_use_b,
  input  logic [AW-1:0] ld_dest,
  input  logic          ld_wen,
  input  logic          ld_is_load,
  output logic          hold
);
  logic ld_live;
  assign ld_live = ld_is_load && ld_wen && (ld_dest != '0);
  assign hold = ld_live && ((dec_use_a && (dec_a == ld_dest)) ||
                            (dec_use_b && (dec_b == ld_dest)));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int AW = REG_AW
) (
  input  logic [IW-1:0] id_instr,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic [IW-1:0] ex_instr,
  input  logic          ex_rr_fmt,
  input  logic          ex_use_rs1,
  input  logic          ex_use_rs2,
  input  logic          ex_store,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [AW-1:0] mem_sd_reg,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          wb_load,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic [1:0]    fwd_sd,
  output logic [1:0]    fwd_mem_sd,
  output logic          stall
);
  localparam int NOPS = 2;

  logic [AW-1:0] id_a, id_b, unused_id_dest;
  logic [AW-1:0] ex_a, ex_b, ex_dest;

  reg_field_split #(.IW(IW), .AW(AW)) u_id_split (
    .instr(id_instr), .rr_fmt(1'b1),
    .src_a(id_a), .src_b(id_b), .dest(unused_id_dest)
  );

  reg_field_split #(.IW(IW), .AW(AW)) u_ex_split (
    .instr(ex_instr), .rr_fmt(ex_rr_fmt),
    .src_a(ex_a), .src_b(ex_b), .dest(ex_dest)
  );

  // ALU operand bypass, one picker per operand
  logic [AW-1:0] op_src [NOPS];
  logic          op_use [NOPS];
  logic [1:0]    op_sel [NOPS];

  assign op_src[0] = ex_a;
  assign op_src[1] = ex_b;
  assign op_use[0] = ex_use_rs1;
  assign op_use[1] = ex_use_rs2;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    byp_pick #(.AW(AW)) u_pick (
      .src(op_src[g]), .used(op_use[g]), .near_ok(1'b1),
      .near_rd(mem_rd), .near_wen(mem_wen),
      .far_rd(wb_rd), .far_wen(wb_wen),
      .sel(op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  // Store data in execute: a load in execute/memory holds an address, not data
  byp_pick #(.AW(AW)) u_sd_pick (
    .src(ex_b), .used(ex_store), .near_ok(!mem_load),
    .near_rd(mem_rd), .near_wen(mem_wen),
    .far_rd(wb_rd), .far_wen(wb_wen),
    .sel(fwd_sd)
  );

  // Store data in memory stage: loaded word from the load just ahead
  byp_pick #(.AW(AW)) u_msd_pick (
    .src(mem_sd_reg), .used(mem_store), .near_ok(1'b0),
    .near_rd(mem_rd), .near_wen(1'b0),
    .far_rd(wb_rd), .far_wen(wb_wen && wb_load),
    .sel(fwd_mem_sd)
  );

  load_use_check #(.AW(AW)) u_lu (
    .dec_a(id_a), .dec_b(id_b),
    .dec_use_a(id_use_rs1), .dec_use_b(id_use_rs2),
    .ld_dest(ex_dest), .ld_wen(ex_wen), .ld_is_load(ex_load),
    .hold(stall)
  );
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int IW = 32,
  parameter int AW = 5
) (
  input logic [IW-1:0] id_instr,
  input logic          id_use_rs1,
  input logic          id_use_rs2,
  input logic [IW-1:0] ex_instr,
  input logic          ex_load,
  input logic          ex_use_rs1,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_load,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic [1:0]    fwd_sd,
  input logic [1:0]    fwd_mem_sd,
  input logic          stall
);
  logic [AW-1:0] chk_ex_a;
  logic unused_chk;
  assign chk_ex_a = ex_instr[21 +: AW];
  assign unused_chk = ^{id_instr, wb_rd};

  always_comb begin
    // R4: register 0 source never bypasses
    a_r4_zero_src: assert (!(chk_ex_a == '0) || fwd_a == 2'b00)
      else $error("a_r4_zero_src");
    // R3: younger stage wins
    a_r3_near_first: assert (!(ex_use_rs1 && mem_wen && mem_rd == chk_ex_a &&
                               chk_ex_a != '0) || fwd_a == 2'b01)
      else $error("a_r3_near_first");
    // R6: only a load in execute stalls, and only for an ALU reader
    a_r6_load_only: assert (!stall || (ex_load && (id_use_rs1 || id_use_rs2)))
      else $error("a_r6_load_only");
    // R5: no writers, no bypass
    a_r5_no_writer: assert (!(!mem_wen && !wb_wen) ||
                            (fwd_a == 2'b00 && fwd_b == 2'b00 && fwd_sd == 2'b00))
      else $error("a_r5_no_writer");
    // R7: store data never taken from a load's address
    a_r7_no_addr: assert (!mem_load || fwd_sd != 2'b01)
      else $error("a_r7_no_addr");
    // R8: memory-stage store select only 00 or 10
    a_r8_codes: assert (fwd_mem_sd == 2'b00 || fwd_mem_sd == 2'b10)
      else $error("a_r8_codes");
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.IW(IW), .AW(AW)) u_chk (
  .id_instr(id_instr), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
  .ex_instr(ex_instr), .ex_load(ex_load), .ex_use_rs1(ex_use_rs1),
  .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
  .wb_rd(wb_rd), .wb_wen(wb_wen),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd), .fwd_mem_sd(fwd_mem_sd),
  .stall(stall)
);

// File: tb/tb_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hazard_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] id_instr, ex_instr;
  logic id_use_rs1, id_use_rs2, ex_rr_fmt, ex_use_rs1, ex_use_rs2;
  logic ex_store, ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen, wb_load;
  logic [4:0] mem_rd, mem_sd_reg, wb_rd;
  logic [1:0] fwd_a, fwd_b, fwd_sd, fwd_mem_sd;
  logic stall;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  hazard_ctrl dut (.*);

  function automatic logic [31:0] mk(input logic [4:0] a, input logic [4:0] b,
                                     input logic [4:0] d);
    return {6'h0, a, b, d, 11'h0};
  endfunction

  function automatic logic [1:0] exp_sel(input logic [4:0] src, input logic used,
      input logic near_ok, input logic [4:0] nrd, input logic nwen,
      input logic [4:0] frd, input logic fwen);
    if (!used || src == 5'd0) return 2'b00;
    if (near_ok && nwen && nrd == src) return 2'b01;
    if (fwen && frd == src) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    logic [4:0] d;
    d = ex_rr_fmt ? ex_instr[15:11] : ex_instr[20:16];
    if (!(ex_load && ex_wen) || d == 5'd0) return 1'b0;
    return (id_use_rs1 && id_instr[25:21] == d) || (id_use_rs2 && id_instr[20:16] == d);
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    id_instr = '0; ex_instr = '0; id_use_rs1 = 0; id_use_rs2 = 0;
    ex_rr_fmt = 1; ex_use_rs1 = 0; ex_use_rs2 = 0; ex_store = 0;
    ex_wen = 0; ex_load = 0; mem_rd = 0; mem_wen = 0; mem_load = 0;
    mem_store = 0; mem_sd_reg = 0; wb_rd = 0; wb_wen = 0; wb_load = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " fwd_a"}, fwd_a, exp_sel(ex_instr[25:21], ex_use_rs1, 1'b1,
                                        mem_rd, mem_wen, wb_rd, wb_wen));
    chk({tag, " fwd_b"}, fwd_b, exp_sel(ex_instr[20:16], ex_use_rs2, 1'b1,
                                        mem_rd, mem_wen, wb_rd, wb_wen));
    chk({tag, " fwd_sd"}, fwd_sd, exp_sel(ex_instr[20:16], ex_store, !mem_load,
                                          mem_rd, mem_wen, wb_rd, wb_wen));
    chk({tag, " fwd_mem_sd"}, fwd_mem_sd, exp_sel(mem_sd_reg, mem_store, 1'b0,
                                                  mem_rd, 1'b0, wb_rd, wb_wen && wb_load));
    chk({tag, " stall"}, {1'b0, stall}, {1'b0, exp_stall()});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    settle();
    // R5 idle / reset state
    chk("R5 idle fwd_a", fwd_a, 2'b00);
    chk("R5 idle fwd_b", fwd_b, 2'b00);
    chk("R5 idle stall", {1'b0, stall}, 2'b00);

    // R1 near forward on operand A
    idle(); ex_instr = mk(5'd3, 5'd7, 5'd1); ex_use_rs1 = 1; mem_rd = 3; mem_wen = 1;
    settle(); chk("R1 near a", fwd_a, 2'b01);
    // R2 far forward on operand B
    idle(); ex_instr = mk(5'd1, 5'd3, 5'd1); ex_use_rs2 = 1; wb_rd = 3; wb_wen = 1;
    settle(); chk("R2 far b", fwd_b, 2'b10);
    // R3 both match
    mem_rd = 3; mem_wen = 1;
    settle(); chk("R3 priority b", fwd_b, 2'b01);
    // R4 register 0
    idle(); ex_instr = mk(5'd0, 5'd0, 5'd0); ex_use_rs1 = 1; ex_use_rs2 = 1;
    mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1;
    settle(); chk("R4 zero a", fwd_a, 2'b00); chk("R4 zero b", fwd_b, 2'b00);
    idle(); ex_instr = mk(5'd2, 5'd2, 5'd0); ex_rr_fmt = 1; ex_load = 1; ex_wen = 1;
    id_instr = mk(5'd0, 5'd0, 5'd0); id_use_rs1 = 1; id_use_rs2 = 1;
    settle(); chk("R4 zero stall", {1'b0, stall}, 2'b00);
    // R5 write enable clear / operand unused
    idle(); ex_instr = mk(5'd6, 5'd6, 5'd1); ex_use_rs1 = 1; mem_rd = 6;
    settle(); chk("R5 wen clear", fwd_a, 2'b00);
    mem_wen = 1; ex_use_rs1 = 0;
    settle(); chk("R5 unused", fwd_a, 2'b00);

    // R6 load-use: stall, then bubble, then far forward
    idle(); ex_instr = mk(5'd9, 5'd9, 5'd5); ex_rr_fmt = 1; ex_load = 1; ex_wen = 1;
    id_instr = mk(5'd5, 5'd8, 5'd2); id_use_rs1 = 1;
    settle(); chk("R6 stall", {1'b0, stall}, 2'b01);
    ex_instr = '0; ex_load = 0; ex_wen = 0; mem_rd = 5; mem_wen = 1; mem_load = 1;
    settle(); chk("R6 one bubble", {1'b0, stall}, 2'b00);
    idle(); ex_instr = mk(5'd5, 5'd8, 5'd2); ex_use_rs1 = 1;
    wb_rd = 5; wb_wen = 1; wb_load = 1;
    settle(); chk("R6 after bubble", fwd_a, 2'b10);

    // R10 destination format
    idle(); ex_instr = mk(5'd1, 5'd6, 5'd4); ex_rr_fmt = 0; ex_load = 1; ex_wen = 1;
    id_instr = mk(5'd2, 5'd6, 5'd0); id_use_rs2 = 1;
    settle(); chk("R10 imm dest", {1'b0, stall}, 2'b01);
    ex_rr_fmt = 1;
    settle(); chk("R10 rr dest", {1'b0, stall}, 2'b00);

    // R9 store data only
    idle(); ex_instr = mk(5'd1, 5'd1, 5'd4); ex_load = 1; ex_wen = 1;
    id_instr = mk(5'd2, 5'd4, 5'd0); id_use_rs1 = 1;
    settle(); chk("R9 store no stall", {1'b0, stall}, 2'b00);

    // R7 store data in execute
    idle(); ex_instr = mk(5'd2, 5'd4, 5'd0); ex_store = 1; mem_rd = 4; mem_wen = 1;
    mem_load = 1;
    settle(); chk("R7 skip load addr", fwd_sd, 2'b00);
    mem_load = 0;
    settle(); chk("R7 near alu", fwd_sd, 2'b01);

    // R8 memory-stage store data
    idle(); mem_store = 1; mem_sd_reg = 4; wb_rd = 4; wb_wen = 1; wb_load = 1;
    settle(); chk("R8 load data", fwd_mem_sd, 2'b10);
    wb_load = 0;
    settle(); chk("R8 not load", fwd_mem_sd, 2'b00);

    // random mix
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 400; i++) begin
      ex_instr = mk(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
      id_instr = mk(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
      {id_use_rs1, id_use_rs2, ex_rr_fmt, ex_use_rs1, ex_use_rs2} = 5'($urandom);
      {ex_store, ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen, wb_load} = 8'($urandom);
      mem_rd = 5'($urandom % 4); mem_sd_reg = 5'($urandom % 4); wb_rd = 5'($urandom % 4);
      settle();
      check_all("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule